// File: doc/BRIEF.md
# Top-Eight Maximum and Index Finder

This block performs a two-stage argmax over one array of signed integers streamed in one element per cycle. In the maximum pass, every accepted element is pushed through an eight-slot insertion buffer that always keeps the eight largest values seen so far, largest first. The buffer is refilled from the most negative representable value at the first element of every maximum pass, so each pass reports only its own array.

The index stage runs as two further passes. A load pass writes eight match values into the match slots, in arrival order. A scan pass then streams the data array again. For every match slot, the block records the zero-based position of the first element equal to that slot's value. A slot that never matches keeps the all-ones not-found marker. Each pass is closed by an element flagged as last. One cycle later the block raises a single-cycle done pulse, together with a length error flag when the pass had an illegal length.

Top module: `top8_argmax`

## Requirements
- R1: After reset every result slot holds the most negative value (0x8000 at the default 16-bit width), every index output holds 0xFFFFFFFF, and done and len_err are low.
- R2: After a maximum pass (mode_sel = 0), slot k of max_vals (bits k*DATA_W upward) holds the (k+1)-th largest value of that pass, so slot 0 holds the largest and slot 7 the smallest of the eight.
- R3: Repeated values each occupy their own slot. A new value equal to a stored value is placed after it.
- R4: Each maximum pass starts from an empty buffer, so values from an earlier pass never appear in the result of a later one.
- R5: done is high for exactly one cycle, in the cycle after the last element of a pass in mode 0, 1 or 2 is accepted, and is low otherwise.
- R6: A maximum or scan pass whose length is below 8 or above 16384 elements raises len_err together with done. Lengths from 8 to 16384 do not raise it.
- R7: A load pass (mode_sel = 1) writes its k-th element, counted from 0, into match slot k. Its length must be exactly 8, and any other length raises len_err with done.
- R8: After a scan pass (mode_sel = 2), the index output of slot k (idx_out bits k*32 upward) holds the zero-based position of the first element equal to match slot k. A later equal element does not replace it.
- R9: At the first element of every scan pass all index outputs restart from 0xFFFFFFFF, and a slot with no equal element ends the pass at 0xFFFFFFFF.
- R10: Match slots that hold equal values all record the same first position.
- R11: Elements presented with mode_sel = 3 are ignored: results, indices and the pass length are unchanged, and no done pulse follows.
- R12: Cycles with in_valid low leave every output unchanged and do not count as elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0 maximum pass, 1 load match values, 2 scan for indices, 3 ignore |
| in_valid | input | 1 | Element present this cycle |
| in_last | input | 1 | Element is the last of its pass |
| in_data | input | DATA_W | Signed element value |
| max_vals | output | NUM_TOP*DATA_W | Eight largest values, slot 0 largest |
| idx_out | output | NUM_TOP*IDX_W | First-match position for each match slot |
| done | output | 1 | One-cycle pulse after the last element of a pass |
| len_err | output | 1 | Pass length illegal, valid with done |

## Verification
The maximum pass is driven with arrays that contain repeated values, strictly rising values, strictly falling values, and only negative values including the most negative code. Together these separate a correct descending insertion from one that drops duplicates, stops shifting early, or keeps stale contents from the previous pass. The scan pass uses a match set with repeated entries, one value absent from the data, and matches at the first and later positions. It then rescans a different array, which exposes a missing first-match lock and a sentinel that is not restored. Lengths of 7, 8, 16384 and 16385 test both error bounds, and a pass with a mid-stream idle cycle and a stream in mode 3 check that non-elements leave no trace.

// File: rtl/argmax_pkg.sv
package argmax_pkg;

    typedef enum logic [1:0] {
        MODE_MAX  = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_SCAN = 2'd2,
        MODE_NONE = 2'd3
    } op_mode_e;

    // Per-element steering produced by the pass tracker
    typedef struct packed {
        logic max_en;
        logic load_en;
        logic scan_en;
        logic first;
    } elem_ctl_t;

endpackage

// File: rtl/argmax_pass_tracker.sv
module argmax_pass_tracker
    import argmax_pkg::*;
#(
    parameter int NUM_TOP = 8,
    parameter int MIN_LEN = 8,
    parameter int MAX_LEN = 16384,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             in_valid,
    input  logic             in_last,
    output elem_ctl_t        ctl,
    output logic [CNT_W-1:0] elem_idx,
    output logic             done,
    output logic             len_err
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_LEN);
    localparam logic [CNT_W:0]   LEN_LO  = (CNT_W+1)'(MIN_LEN);
    localparam logic [CNT_W:0]   LEN_HI  = (CNT_W+1)'(MAX_LEN);
    localparam logic [CNT_W:0]   LEN_LD  = (CNT_W+1)'(NUM_TOP);

    op_mode_e         mode;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             accept;
    logic [CNT_W:0]   pass_len;
    logic             bad_len;

    assign mode     = op_mode_e'(mode_sel);
    assign accept   = in_valid && (mode != MODE_NONE);
    assign pass_len = {1'b0, cnt_q} + 1'b1;
    assign bad_len  = (mode == MODE_LOAD) ? (ovf_q || pass_len != LEN_LD)
                                          : (ovf_q || pass_len < LEN_LO || pass_len > LEN_HI);

    assign ctl.max_en  = in_valid && (mode == MODE_MAX);
    assign ctl.load_en = in_valid && (mode == MODE_LOAD);
    assign ctl.scan_en = in_valid && (mode == MODE_SCAN);
    assign ctl.first   = (cnt_q == '0) && !ovf_q;
    assign elem_idx    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            done    <= 1'b0;
            len_err <= 1'b0;
        end else begin
            done    <= accept && in_last;
            len_err <= accept && in_last && bad_len;
            if (accept) begin
                if (in_last) begin
                    cnt_q <= '0;
                    ovf_q <= 1'b0;
                end else if (cnt_q == CNT_TOP) begin
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/argmax_sorter.sv
module argmax_sorter #(
    parameter int DATA_W  = 16,
    parameter int NUM_TOP = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        first,
    input  logic signed [DATA_W-1:0]    din,
    output logic [NUM_TOP*DATA_W-1:0]   vals
);
    localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] slot_q [NUM_TOP];
    logic signed [DATA_W-1:0] cur    [NUM_TOP];
    logic signed [DATA_W-1:0] nxt    [NUM_TOP];
    logic [NUM_TOP-1:0]       gt;

    for (genvar k = 0; k < NUM_TOP; k++) begin : g_slot
        assign cur[k] = first ? MOST_NEG : slot_q[k];
        // strict compare: an equal value settles below the stored one
        assign gt[k]  = din > cur[k];
        if (k == 0) begin : g_head
            assign nxt[k] = gt[k] ? din : cur[k];
        end else begin : g_body
            assign nxt[k] = gt[k] ? (gt[k-1] ? cur[k-1] : din) : cur[k];
        end
        always_ff @(posedge clk) begin
            if (rst)     slot_q[k] <= MOST_NEG;
            else if (en) slot_q[k] <= nxt[k];
        end
        assign vals[k*DATA_W +: DATA_W] = slot_q[k];
    end
endmodule

// File: rtl/argmax_matcher.sv
module argmax_matcher #(
    parameter int DATA_W  = 16,
    parameter int NUM_TOP = 8,
    parameter int IDX_W   = 32,
    parameter int CNT_W   = 15
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_en,
    input  logic                       scan_en,
    input  logic                       first,
    input  logic [CNT_W-1:0]           elem_idx,
    input  logic signed [DATA_W-1:0]   din,
    output logic [NUM_TOP*IDX_W-1:0]   idx
);
    localparam logic [IDX_W-1:0] NOT_FOUND = '1;

    logic signed [DATA_W-1:0] match_q [NUM_TOP];
    logic [IDX_W-1:0]         idx_q   [NUM_TOP];
    logic [NUM_TOP-1:0]       hit_q;

    for (genvar k = 0; k < NUM_TOP; k++) begin : g_slot
        logic             hit_cur;
        logic [IDX_W-1:0] idx_cur;
        assign hit_cur = first ? 1'b0 : hit_q[k];
        assign idx_cur = first ? NOT_FOUND : idx_q[k];

        always_ff @(posedge clk) begin
            if (rst) begin
                match_q[k] <= '0;
                idx_q[k]   <= NOT_FOUND;
                hit_q[k]   <= 1'b0;
            end else begin
                if (load_en && elem_idx == CNT_W'(k))
                    match_q[k] <= din;
                if (scan_en) begin
                    if (!hit_cur && din == match_q[k]) begin
                        idx_q[k] <= IDX_W'(elem_idx);
                        hit_q[k] <= 1'b1;
                    end else begin
                        idx_q[k] <= idx_cur;
                        hit_q[k] <= hit_cur;
                    end
                end
            end
        end
        assign idx[k*IDX_W +: IDX_W] = idx_q[k];
    end
endmodule

// File: rtl/top8_argmax.sv
module top8_argmax
    import argmax_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_TOP = 8,
    parameter int IDX_W   = 32,
    parameter int MIN_LEN = 8,
    parameter int MAX_LEN = 16384
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  mode_sel,
    input  logic                        in_valid,
    input  logic                        in_last,
    input  logic signed [DATA_W-1:0]    in_data,
    output logic [NUM_TOP*DATA_W-1:0]   max_vals,
    output logic [NUM_TOP*IDX_W-1:0]    idx_out,
    output logic                        done,
    output logic                        len_err
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    elem_ctl_t        ctl;
    logic [CNT_W-1:0] elem_idx;

    argmax_pass_tracker #(
        .NUM_TOP(NUM_TOP), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)
    ) u_track (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid),
        .in_last(in_last), .ctl(ctl), .elem_idx(elem_idx),
        .done(done), .len_err(len_err)
    );

    argmax_sorter #(.DATA_W(DATA_W), .NUM_TOP(NUM_TOP)) u_sort (
        .clk(clk), .rst(rst), .en(ctl.max_en), .first(ctl.first),
        .din(in_data), .vals(max_vals)
    );

    argmax_matcher #(
        .DATA_W(DATA_W), .NUM_TOP(NUM_TOP), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_match (
        .clk(clk), .rst(rst), .load_en(ctl.load_en), .scan_en(ctl.scan_en),
        .first(ctl.first), .elem_idx(elem_idx), .din(in_data), .idx(idx_out)
    );
endmodule

// File: rtl/top8_argmax_chk.sv
module top8_argmax_chk #(
    parameter int DATA_W  = 16,
    parameter int NUM_TOP = 8,
    parameter int IDX_W   = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 mode_sel,
    input logic                       in_valid,
    input logic                       in_last,
    input logic [NUM_TOP*DATA_W-1:0]  max_vals,
    input logic [NUM_TOP*IDX_W-1:0]   idx_out,
    input logic                       done,
    input logic                       len_err
);
    logic desc_ok;
    always_comb begin
        desc_ok = 1'b1;
        for (int k = 1; k < NUM_TOP; k++)
            if ($signed(max_vals[k*DATA_W +: DATA_W]) > $signed(max_vals[(k-1)*DATA_W +: DATA_W]))
                desc_ok = 1'b0;
    end

    AST_ORDERED_SLOTS: assert property (@(posedge clk) disable iff (rst)
        desc_ok);                                                            // R2
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_last && mode_sel != 2'b11));           // R5
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        len_err |-> done);                                                   // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(max_vals) && $stable(idx_out) && !done));     // R12
    AST_IGNORED_MODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel == 2'b11) |=> ($stable(max_vals) && $stable(idx_out) && !done)); // R11
    AST_MAX_ONLY_IN_MAX: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel != 2'b00) |=> $stable(max_vals));              // R4
endmodule

bind top8_argmax top8_argmax_chk #(
    .DATA_W(DATA_W), .NUM_TOP(NUM_TOP), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_last(in_last), .max_vals(max_vals), .idx_out(idx_out),
    .done(done), .len_err(len_err)
);

// File: tb/top8_argmax_test.sv
module top8_argmax_test;
    localparam int DW   = 16;
    localparam int NT   = 8;
    localparam int IW   = 32;
    localparam int MAXL = 16384;
    localparam logic signed [DW-1:0] NEG = 16'sh8000;

    localparam logic signed [DW-1:0] TBL [4][12] = '{
        '{16'sd3, -16'sd7, 16'sd12, 16'sd12, 16'sd0, 16'sd45, -16'sd100, 16'sd45, 16'sd8, 16'sd1, 16'sd12, 16'sd2},
        '{16'sd1, 16'sd2, 16'sd3, 16'sd4, 16'sd5, 16'sd6, 16'sd7, 16'sd8, 16'sd9, 16'sd10, 16'sd11, 16'sd12},
        '{16'sd100, 16'sd90, 16'sd80, 16'sd70, 16'sd60, 16'sd50, 16'sd40, 16'sd30, 16'sd20, 16'sd10, 16'sd0, -16'sd10},
        '{-16'sd50, -16'sd3, -16'sd3, -16'sd40, -16'sd9, 16'sh8000, -16'sd1, -16'sd20, -16'sd3, -16'sd7, -16'sd11, -16'sd2}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst;
    logic [1:0]           mode_sel;
    logic                 in_valid, in_last;
    logic signed [DW-1:0] in_data;
    logic [NT*DW-1:0]     max_vals;
    logic [NT*IW-1:0]     idx_out;
    logic                 done, len_err;

    top8_argmax uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .in_valid(in_valid),
        .in_last(in_last), .in_data(in_data), .max_vals(max_vals),
        .idx_out(idx_out), .done(done), .len_err(len_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic signed [DW-1:0] arr [MAXL+1];
    int arr_len;
    logic signed [DW-1:0] ref_top [NT];
    logic signed [DW-1:0] ref_match [NT];
    logic [IW-1:0]        ref_idx [NT];

    task automatic chk(input string req, input logic [IW-1:0] act, input logic [IW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_max();
        for (int k = 0; k < NT; k++) ref_top[k] = NEG;
        for (int e = 0; e < arr_len; e++) begin
            int pos = NT;
            for (int k = NT-1; k >= 0; k--) if (arr[e] > ref_top[k]) pos = k;
            if (pos < NT) begin
                for (int k = NT-1; k > pos; k--) ref_top[k] = ref_top[k-1];
                ref_top[pos] = arr[e];
            end
        end
    endtask

    task automatic model_scan();
        for (int k = 0; k < NT; k++) ref_idx[k] = '1;
        for (int e = 0; e < arr_len; e++)
            for (int k = 0; k < NT; k++)
                if (ref_idx[k] == '1 && arr[e] == ref_match[k]) ref_idx[k] = IW'(e);
    endtask

    task automatic run_pass(input logic [1:0] m, input bit gap);
        for (int e = 0; e < arr_len; e++) begin
            if (gap && e == 3) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
                in_data  = 16'sd32000;
            end
            @(negedge clk);
            mode_sel = m;
            in_valid = 1'b1;
            in_data  = arr[e];
            in_last  = (e == arr_len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic chk_end(input string req, input bit exp_err);
        chk({req, " done pulse"}, IW'(done), IW'(1));
        chk({req, " len_err"}, IW'(len_err), IW'(exp_err));
        @(negedge clk);
        chk("R5 done falls", IW'(done), IW'(0));
    endtask

    task automatic chk_top(input string req);
        for (int k = 0; k < NT; k++)
            chk(req, IW'(max_vals[k*DW +: DW]), IW'($unsigned(ref_top[k])));
    endtask

    task automatic chk_idx(input string req);
        for (int k = 0; k < NT; k++)
            chk(req, idx_out[k*IW +: IW], ref_idx[k]);
    endtask

    initial begin
        #(3_000_000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [NT*DW-1:0] snap_v;
        logic [NT*IW-1:0] snap_i;
        rst = 1'b1; mode_sel = 2'd0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < NT; k++) begin
            chk("R1 reset value", IW'(max_vals[k*DW +: DW]), IW'(16'h8000));
            chk("R1 reset index", idx_out[k*IW +: IW], 32'hFFFF_FFFF);
        end
        chk("R1 reset done", IW'(done), 0);
        chk("R1 reset err", IW'(len_err), 0);

        // Table walk: R2 ordering, R3 duplicates (row 0), R4 fresh start (row 3 after row 2)
        for (int v = 0; v < 4; v++) begin
            arr_len = 12;
            for (int e = 0; e < 12; e++) arr[e] = TBL[v][e];
            model_max();
            run_pass(2'd0, 1'b0);
            chk_top(v == 0 ? "R3 duplicates kept" : (v == 3 ? "R4 fresh pass" : "R2 descending"));
            chk_end("R5 max pass", 1'b0);
        end

        // R12 idle cycle mid-pass does not count
        arr_len = 12;
        for (int e = 0; e < 12; e++) arr[e] = TBL[0][e];
        model_max();
        run_pass(2'd0, 1'b1);
        chk_top("R12 gap ignored");
        chk_end("R12 gap pass", 1'b0);

        // R7 load match values
        ref_match = '{16'sd5, 16'sd7, 16'sd5, 16'sd100, -16'sd3, 16'sd9, 16'sd42, 16'sd7};
        arr_len = 8;
        for (int e = 0; e < 8; e++) arr[e] = ref_match[e];
        run_pass(2'd1, 1'b0);
        chk_end("R7 load", 1'b0);

        // R8 first match, R10 shared values, R9 absent value keeps sentinel
        arr_len = 10;
        arr[0] = 16'sd9;  arr[1] = 16'sd5;  arr[2] = -16'sd3; arr[3] = 16'sd7;
        arr[4] = 16'sd5;  arr[5] = 16'sd0;  arr[6] = 16'sd7;  arr[7] = 16'sd42;
        arr[8] = -16'sd3; arr[9] = 16'sd1;
        model_scan();
        run_pass(2'd2, 1'b0);
        chk_idx("R8 first match");
        chk("R10 equal slots", idx_out[2*IW +: IW], idx_out[0*IW +: IW]);
        chk("R9 absent", idx_out[3*IW +: IW], 32'hFFFF_FFFF);
        chk_end("R8 scan", 1'b0);
        chk_top("R4 scan leaves maxima");

        // R9 rescan restores sentinel
        arr_len = 10;
        arr[0] = 16'sd100;
        for (int e = 1; e < 10; e++) arr[e] = DW'(e + 1000);
        model_scan();
        run_pass(2'd2, 1'b0);
        chk_idx("R9 rescan sentinel");
        chk_end("R9 rescan", 1'b0);

        // R11 mode 3 ignored
        snap_v = max_vals; snap_i = idx_out;
        arr_len = 10;
        for (int e = 0; e < 10; e++) arr[e] = 16'sd30000;
        run_pass(2'd3, 1'b0);
        chk("R11 no done", IW'(done), 0);
        chk("R11 values held", IW'(max_vals != snap_v), 0);
        chk("R11 indices held", IW'(idx_out != snap_i), 0);

        // R6 length bounds
        arr_len = 7;
        for (int e = 0; e < 7; e++) arr[e] = DW'(e);
        run_pass(2'd0, 1'b0);
        chk_end("R6 max len 7", 1'b1);
        run_pass(2'd2, 1'b0);
        chk_end("R6 scan len 7", 1'b1);
        arr_len = 8;
        model_max();
        run_pass(2'd0, 1'b0);
        chk_top("R2 len 8");
        chk_end("R6 len 8", 1'b0);

        // R7 load of wrong length
        arr_len = 9;
        run_pass(2'd1, 1'b0);
        chk_end("R7 load len 9", 1'b1);

        arr_len = MAXL;
        for (int e = 0; e < MAXL + 1; e++) arr[e] = DW'((e * 7919) % 20011 - 10000);
        model_max();
        run_pass(2'd0, 1'b0);
        chk_top("R2 len 16384");
        chk_end("R6 len 16384", 1'b0);
        arr_len = MAXL + 1;
        run_pass(2'd0, 1'b0);
        chk_end("R6 len 16385", 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule